// File: doc/BRIEF.md
# Valley Lockout Selector

This block picks the valley of the drain ringing on which a quasi-resonant converter turns its switch on. It takes two digital inputs: the current setpoint, as a whole percentage of full reference, and a digitised line voltage in volts. It returns the selected valley number and a flag that asks for frequency-foldback operation.

The decision has two axes. First, the line is sorted into a low or a high range. Separate entry and exit levels give hysteresis, and a blanking counter makes sure a new range only counts once it has lasted long enough. Second, the setpoint is compared against a ladder of thresholds. Each rung has one level for a falling setpoint and a higher level for a rising one, so a chosen valley stays locked until the setpoint moves well away from it. The high line range moves the whole ladder up by one valley. Below the lowest rung, the selector holds the deepest valley and raises the foldback flag.

Every clock is one evaluation. The selector moves at most one valley per clock, so a large jump in the setpoint walks through the ladder rather than skipping rungs.

Top module: `valley_lockout_sel`

## Requirements
- R1: While reset is asserted, and just after it, the line range is low, the valley number is 1 and the foldback flag is 0.
- R2: In the low range, a line value above 264 that lasts BLANK_CYC consecutive clocks switches to the high range on the last of those clocks. A shorter excursion, or one that is interrupted, changes nothing.
- R3: In the high range, only a line value below 253 that lasts BLANK_CYC consecutive clocks returns to the low range. Values from 253 to 264 inclusive keep whichever range is current.
- R4: The valley number is the ladder position (0 to 4) plus 1 in the low range and plus 2 in the high range. An undimmed setpoint therefore gives valley 1 at low line and valley 2 at high line.
- R5: A setpoint below 80, 65, 50 or 35 moves the ladder down from position 0, 1, 2 or 3 respectively, which raises the valley number by one. A setpoint exactly at the threshold does not move it.
- R6: A setpoint above 85, 70, 55 or 40 moves the ladder up from position 1, 2, 3 or 4 respectively, which lowers the valley number by one. Between a position's two levels, the position holds.
- R7: At ladder position 4, a setpoint below 25 sets the foldback flag. While the flag is set, the valley stays at 5 (low line) or 6 (high line).
- R8: The foldback flag clears only when the setpoint rises above 35. Setpoints from 25 to 35 keep it set, and no valley step happens on the clock that clears it.
- R9: The valley number changes by at most one per clock.
- R10: On a clock where the line range changes, the ladder position does not step, so the valley moves by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock |
| rstN | input | 1 | Active-low synchronous reset |
| setpointPct | input | SP_W (7) | Current setpoint, percent of full reference |
| lineVolts | input | LINE_W (10) | Digitised line voltage in volts |
| valleyNum | output | VAL_W (3) | Selected valley, 1-based |
| foldMode | output | 1 | Frequency-foldback request |

## Verification
A wrong internal state is never hidden for long. If the ladder position is wrong, the valley output is wrong on the very next sample, because that output comes straight from registered state. A fault in the line-range state shows up the same way: it appears as an off-by-one valley at a setpoint that is steady.

A fault in the blanking counter is harder to see. It only shows as a range switch one or more clocks early or late, so the checks sample at the clock just before the expected switch and at the clock on which it should happen. Errors in the hysteresis levels only show when the setpoint is held between a rung's two levels or exactly on a threshold, so the checks hold the setpoint there.

// File: rtl/vly_pkg.sv
package vly_pkg;

  // Control-to-datapath strobes, at most one asserted per clock
  typedef struct packed {
    logic stepDeeper;   // move one ladder position down (higher valley)
    logic stepShallow;  // move one ladder position up (lower valley)
    logic foldSet;      // enter frequency foldback
    logic foldClr;      // leave frequency foldback
  } vlyStrobe_t;

endpackage

// File: rtl/vly_ctrl.sv
module vly_ctrl
  import vly_pkg::*;
#(
  parameter int SP_W       = 7,
  parameter int LINE_W     = 10,
  parameter int HI_LINE    = 264,
  parameter int LO_LINE    = 253,
  parameter int BLANK_CYC  = 25000,
  parameter int NUM_LEVELS = 5,
  parameter int FIRST_FALL = 80,
  parameter int FALL_STEP  = 15,
  parameter int HYST       = 5,
  parameter int FOLD_IN    = 25,
  parameter int FOLD_OUT   = 35,
  localparam int LVL_W     = $clog2(NUM_LEVELS),
  localparam int CNT_W     = $clog2(BLANK_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SP_W-1:0]   setpointPct,
  input  logic [LINE_W-1:0] lineVolts,
  input  logic [LVL_W-1:0]  level,
  input  logic              foldMode,
  output logic              rangeHigh,
  output vlyStrobe_t        strobe
);

  localparam int LAST = NUM_LEVELS - 1;

  logic [CNT_W-1:0]      blankCnt;
  logic                  lineCand;
  logic                  rangeFlip;
  logic [NUM_LEVELS-1:0] belowFall;
  logic [NUM_LEVELS-1:0] aboveRise;
  logic [NUM_LEVELS-1:0] levelSel;

  // Line-range classifier: candidate condition depends on current range
  assign lineCand  = rangeHigh ? (int'(lineVolts) < LO_LINE)
                               : (int'(lineVolts) > HI_LINE);
  assign rangeFlip = lineCand && (blankCnt == CNT_W'(BLANK_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeHigh <= 1'b0;
      blankCnt  <= '0;
    end else if (rangeFlip) begin
      rangeHigh <= ~rangeHigh;
      blankCnt  <= '0;
    end else if (lineCand) begin
      blankCnt  <= blankCnt + 1'b1;
    end else begin
      blankCnt  <= '0;
    end
  end

  // Threshold ladder: per position, a falling exit and a rising exit
  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_rung
    if (k == LAST) begin : g_fall_none
      assign belowFall[k] = 1'b0;
    end else begin : g_fall
      localparam int FALL_LVL = FIRST_FALL - FALL_STEP * k;
      assign belowFall[k] = int'(setpointPct) < FALL_LVL;
    end
    if (k == 0) begin : g_rise_none
      assign aboveRise[k] = 1'b0;
    end else begin : g_rise
      localparam int RISE_LVL = FIRST_FALL - FALL_STEP * (k - 1) + HYST;
      assign aboveRise[k] = int'(setpointPct) > RISE_LVL;
    end
    assign levelSel[k] = (level == LVL_W'(k));
  end

  logic fallHit;
  logic riseHit;
  assign fallHit = |(belowFall & levelSel);
  assign riseHit = |(aboveRise & levelSel);

  always_comb begin
    strobe             = '0;
    strobe.foldClr     = foldMode && (int'(setpointPct) > FOLD_OUT);
    strobe.foldSet     = !foldMode && levelSel[LAST] && (int'(setpointPct) < FOLD_IN);
    strobe.stepDeeper  = !foldMode && !rangeFlip && fallHit;
    strobe.stepShallow = !foldMode && !rangeFlip && riseHit;
  end

  // R2: entering the high range needs the line above the upper level
  assert_range_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rangeHigh) |-> $past(int'(lineVolts) > HI_LINE));

  // R3: leaving the high range needs the line below the lower level
  assert_range_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rangeHigh) |-> $past(int'(lineVolts) < LO_LINE));

  // R8: foldback ends only after a setpoint above the exit level
  assert_fold_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(foldMode) |-> $past(int'(setpointPct) > FOLD_OUT));

endmodule

// File: rtl/vly_dp.sv
module vly_dp
  import vly_pkg::*;
#(
  parameter int NUM_LEVELS = 5,
  localparam int LVL_W     = $clog2(NUM_LEVELS),
  localparam int VAL_W     = $clog2(NUM_LEVELS + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  vlyStrobe_t       strobe,
  input  logic             rangeHigh,
  output logic [LVL_W-1:0] level,
  output logic             foldMode,
  output logic [VAL_W-1:0] valleyNum
);

  localparam int LAST = NUM_LEVELS - 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level    <= '0;
      foldMode <= 1'b0;
    end else begin
      if (strobe.stepDeeper)       level <= level + 1'b1;
      else if (strobe.stepShallow) level <= level - 1'b1;
      if (strobe.foldSet)          foldMode <= 1'b1;
      else if (strobe.foldClr)     foldMode <= 1'b0;
    end
  end

  // Line range shifts the whole ladder by one valley
  assign valleyNum = VAL_W'(level) + VAL_W'(1) + VAL_W'(rangeHigh);

  // Strobes from control are mutually exclusive
  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R9: ladder position moves by at most one per clock
  assert_one_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (level == $past(level)) || (level == $past(level) + 1'b1) ||
    (level + 1'b1 == $past(level)));

  // R7: foldback only in the deepest ladder position
  assert_fold_deepest_R7: assert property (@(posedge clk) disable iff (!rstN)
    foldMode |-> (level == LVL_W'(LAST)));

  // R10: no ladder step on a clock where the range changes
  assert_no_double_move_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rangeHigh) |-> $stable(level));

endmodule

// File: rtl/valley_lockout_sel.sv
module valley_lockout_sel
  import vly_pkg::*;
#(
  parameter int SP_W       = 7,
  parameter int LINE_W     = 10,
  parameter int HI_LINE    = 264,
  parameter int LO_LINE    = 253,
  parameter int BLANK_CYC  = 25000,
  parameter int NUM_LEVELS = 5,
  parameter int FIRST_FALL = 80,
  parameter int FALL_STEP  = 15,
  parameter int HYST       = 5,
  parameter int FOLD_IN    = 25,
  parameter int FOLD_OUT   = 35,
  localparam int VAL_W     = $clog2(NUM_LEVELS + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SP_W-1:0]   setpointPct,
  input  logic [LINE_W-1:0] lineVolts,
  output logic [VAL_W-1:0]  valleyNum,
  output logic              foldMode
);

  localparam int LVL_W = $clog2(NUM_LEVELS);

  vlyStrobe_t       strobe;
  logic             rangeHigh;
  logic [LVL_W-1:0] level;

  vly_ctrl #(
    .SP_W(SP_W), .LINE_W(LINE_W), .HI_LINE(HI_LINE), .LO_LINE(LO_LINE),
    .BLANK_CYC(BLANK_CYC), .NUM_LEVELS(NUM_LEVELS), .FIRST_FALL(FIRST_FALL),
    .FALL_STEP(FALL_STEP), .HYST(HYST), .FOLD_IN(FOLD_IN), .FOLD_OUT(FOLD_OUT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .setpointPct(setpointPct), .lineVolts(lineVolts),
    .level(level), .foldMode(foldMode), .rangeHigh(rangeHigh), .strobe(strobe)
  );

  vly_dp #(.NUM_LEVELS(NUM_LEVELS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rangeHigh(rangeHigh),
    .level(level), .foldMode(foldMode), .valleyNum(valleyNum)
  );

  // R4: output valley always inside the shifted ladder
  assert_valley_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (valleyNum >= VAL_W'(1)) && (valleyNum <= VAL_W'(NUM_LEVELS + 1)));

endmodule

// File: tb/test_valley_lockout_sel.sv
module test_valley_lockout_sel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] setpointPct = 7'd100;
  logic [9:0] lineVolts = 10'd230;
  logic [2:0] valleyNum;
  logic       foldMode;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  valley_lockout_sel #(.BLANK_CYC(6)) i_valley_lockout_sel (
    .clk(clk), .rstN(rstN), .setpointPct(setpointPct), .lineVolts(lineVolts),
    .valleyNum(valleyNum), .foldMode(foldMode)
  );

  // entry: [24:18] setpoint, [17:8] line, [7:4] ticks, [3:1] valley, [0] fold
  localparam int NVEC = 18;
  localparam logic [31:0] VEC [NVEC] = '{
    {7'd0, 7'd100, 10'd230, 4'd1, 3'd1, 1'b0},  // R4 undimmed low line
    {7'd0, 7'd79,  10'd230, 4'd1, 3'd2, 1'b0},  // R5 below 80
    {7'd0, 7'd82,  10'd230, 4'd1, 3'd2, 1'b0},  // R6 inside band holds
    {7'd0, 7'd86,  10'd230, 4'd1, 3'd1, 1'b0},  // R6 above 85
    {7'd0, 7'd84,  10'd230, 4'd1, 3'd1, 1'b0},  // R6 hold
    {7'd0, 7'd80,  10'd230, 4'd1, 3'd1, 1'b0},  // R5 exactly 80
    {7'd0, 7'd64,  10'd230, 4'd1, 3'd2, 1'b0},  // R9 one step
    {7'd0, 7'd64,  10'd230, 4'd1, 3'd3, 1'b0},  // R5 below 65
    {7'd0, 7'd64,  10'd230, 4'd1, 3'd3, 1'b0},  // R5 hold
    {7'd0, 7'd0,   10'd230, 4'd1, 3'd4, 1'b0},  // R9 jump walks
    {7'd0, 7'd0,   10'd230, 4'd1, 3'd5, 1'b0},  // R9
    {7'd0, 7'd0,   10'd230, 4'd1, 3'd5, 1'b1},  // R7 enter fold
    {7'd0, 7'd30,  10'd230, 4'd3, 3'd5, 1'b1},  // R8 hold fold
    {7'd0, 7'd36,  10'd230, 4'd1, 3'd5, 1'b0},  // R8 exit fold
    {7'd0, 7'd36,  10'd230, 4'd1, 3'd5, 1'b0},  // R6 hold below 40
    {7'd0, 7'd41,  10'd230, 4'd1, 3'd4, 1'b0},  // R6 above 40
    {7'd0, 7'd100, 10'd230, 4'd1, 3'd3, 1'b0},  // R9
    {7'd0, 7'd100, 10'd230, 4'd3, 3'd1, 1'b0}   // R9 walk back
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [2:0] expV, input logic expF);
    checks++;
    if (valleyNum !== expV || foldMode !== expF) begin
      errors++;
      $display("FAIL %s: valley=%0d fold=%0d expected valley=%0d fold=%0d",
               req, valleyNum, foldMode, expV, expF);
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    check("R1", 3'd1, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      setpointPct = VEC[i][24:18];
      lineVolts   = VEC[i][17:8];
      tick(int'(VEC[i][7:4]));
      check($sformatf("vector %0d", i), VEC[i][3:1], VEC[i][0]);
    end

    // R2: short excursion, interruption, then full blanking
    lineVolts = 10'd270; tick(5); check("R2", 3'd1, 1'b0);
    lineVolts = 10'd250; tick(1); check("R2", 3'd1, 1'b0);
    lineVolts = 10'd270; tick(5); check("R2", 3'd1, 1'b0);
    tick(1); check("R4", 3'd2, 1'b0);
    // R3: hysteresis band keeps high range
    lineVolts = 10'd255; tick(10); check("R3", 3'd2, 1'b0);
    // R5 at high line, then deepest valley and foldback
    lineVolts = 10'd270; setpointPct = 7'd79; tick(1); check("R5", 3'd3, 1'b0);
    setpointPct = 7'd0; tick(3); check("R9", 3'd6, 1'b0);
    tick(1); check("R7", 3'd6, 1'b1);
    // R8 exit and walk back at high line
    setpointPct = 7'd100; lineVolts = 10'd255; tick(1); check("R8", 3'd6, 1'b0);
    tick(5); check("R6", 3'd2, 1'b0);
    // R3 blanking, then R10 range change blocks the step
    lineVolts = 10'd240; tick(5); check("R3", 3'd2, 1'b0);
    setpointPct = 7'd70; tick(1); check("R10", 3'd1, 1'b0);
    tick(1); check("R5", 3'd2, 1'b0);
    // R1: reset mid-run
    rstN = 1'b0; tick(1); check("R1", 3'd1, 1'b0);
    rstN = 1'b1; setpointPct = 7'd100; tick(1); check("R1", 3'd1, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule